// File: doc/BRIEF.md
# Interrupt CPU-Interface Priority Register Block

This block holds the priority bookkeeping registers of one interrupt-controller CPU interface. Physical processors and virtual processors share it. Each request on its simple register bus carries an offset, read and write strobes, write data, a non-secure attribute, a virtual-requester flag and a processor index. The block uses those attributes to pick the storage that the access reaches. A physical secure requester sees its own active-priority words directly. A physical non-secure requester sees a shifted window onto the upper half of those words. A virtual requester sees one active-priority word that the hypervisor owns, and it has its own binary-point register with a higher floor.

Accesses that are not allowed read as zero and drop their write data, with no error. A write to the end-of-interrupt offset is not stored. The block instead sends a one-cycle notification that carries the 10-bit interrupt number, the requester index and the virtual flag.

Top module: `cpuif_prio_regs`

## Requirements
- R1: After reset, every active-priority word, every non-secure active-priority word and every hypervisor word reads zero. A physical binary-point register reads 0 and a virtual binary-point register reads 2.
- R2: The active-priority words sit at offsets 0xD0 + 4n, and n is the word index. A secure physical access to word n (n below 4) reads or writes word n of the requesting processor only.
- R3: A non-secure physical access to active-priority index n with n < 2 reaches secure word n + 2 of the same processor. For index 2 or 3 it reads zero and the write is dropped.
- R4: A virtual access to active-priority index 0 reaches the hypervisor word of processor req_cpu. That word is separate from the physical words. Virtual indexes 1 to 3 read zero and their writes are dropped.
- R5: The non-secure active-priority words sit at offsets 0xE0 + 4n, with n below 4. A secure physical access reads and writes them per processor. A non-secure or virtual access reads zero and its write is dropped.
- R6: When the revision parameter is not 2, all accesses to 0xD0–0xEF read zero and drop their writes. When interrupt groups are absent, 0xE0–0xEF read zero.
- R7: The binary-point register sits at offset 0x08 and reads back in bits [2:0], with zeros above. A write stores max(wdata[2:0], 0) for a physical requester. For a virtual requester it stores max(wdata[2:0], 2) in a separate per-processor register.
- R8: A write to offset 0x10 raises eoi_valid for exactly the next cycle. In that cycle eoi_id = wdata[9:0], and eoi_cpu and eoi_virtual echo the request.
- R9: rd_data is registered. It is valid the cycle after req_rd and holds until the next read. Unmapped or misaligned offsets read zero.
- R10: When req_rd and req_wr hit the same register in one cycle, the read returns the contents from before the write, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_offset | input | 12 | Byte offset of the access |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_wdata | input | 32 | Write data |
| req_nonsecure | input | 1 | Non-secure access attribute |
| req_virtual | input | 1 | Requester is a virtual processor |
| req_cpu | input | CPU_W (2) | Processor index (hosting processor for virtual requests) |
| rd_data | output | 32 | Registered read data |
| eoi_valid | output | 1 | End-of-interrupt notification pulse |
| eoi_id | output | 10 | Interrupt number of the notification |
| eoi_cpu | output | CPU_W (2) | Processor index of the notification |
| eoi_virtual | output | 1 | Notification came from a virtual requester |

## Verification
A read and a write can both be active in the same cycle. When they target the same active-priority word, the registered read path and the bank update race at one clock edge. The bench provokes this by asserting both strobes on a word that already holds a known value. It expects the old value on rd_data in the following cycle and the new value on a later plain read. A second case checks that a write-only cycle after a read, including an end-of-interrupt write, leaves rd_data unchanged while the notification fires.

// File: rtl/cpuif_prio_pkg.sv
package cpuif_prio_pkg;

   localparam int ADDR_W  = 12;
   localparam int DATA_W  = 32;
   localparam int SLOT_W  = 2;   // four word slots per priority window
   localparam int BPR_W   = 3;
   localparam int INTID_W = 10;
   localparam int WIN_W   = ADDR_W - 4;

   localparam logic [ADDR_W-1:0] OFF_BPR   = 12'h008;
   localparam logic [ADDR_W-1:0] OFF_EOI   = 12'h010;
   localparam logic [WIN_W-1:0]  WIN_APR   = 8'h0D;
   localparam logic [WIN_W-1:0]  WIN_NSAPR = 8'h0E;

   typedef enum logic [2:0] {
      SRC_NONE,
      SRC_APR,
      SRC_NSAPR,
      SRC_HYP,
      SRC_BPR,
      SRC_VBPR
   } src_e;

   function automatic logic [BPR_W-1:0] bpr_clamp(input logic [BPR_W-1:0] v,
                                                  input logic [BPR_W-1:0] floor_v);
      return (v < floor_v) ? floor_v : v;
   endfunction

endpackage

// File: rtl/cpuif_decode.sv
module cpuif_decode
   import cpuif_prio_pkg::*;
#(
   parameter int PHYS_APR_COUNT = 4,
   parameter int VIRT_APR_COUNT = 1,
   parameter int ARCH_REV       = 2,
   parameter bit HAS_GROUPS     = 1'b1
) (
   input  logic [ADDR_W-1:0] offset,
   input  logic              nonsecure,
   input  logic              virt,
   output src_e              src,
   output logic [SLOT_W-1:0] slot,
   output logic              is_eoi
);

   localparam int HALF = PHYS_APR_COUNT / 2;
   localparam logic [SLOT_W-1:0] HALF_S = SLOT_W'(HALF);
   localparam bit REV_OK = (ARCH_REV == 2);

   logic [WIN_W-1:0]  win;
   logic [SLOT_W-1:0] slot_raw;
   logic              aligned;

   assign win      = offset[ADDR_W-1:4];
   assign slot_raw = offset[3:2];
   assign aligned  = (offset[1:0] == 2'b00);

   always_comb begin
      src    = SRC_NONE;
      slot   = slot_raw;
      is_eoi = 1'b0;
      if (aligned && win == WIN_APR && REV_OK) begin
         if (virt) begin
            if (int'(slot_raw) < VIRT_APR_COUNT) src = SRC_HYP;
         end else if (nonsecure) begin
            if (int'(slot_raw) < HALF) begin
               src  = SRC_APR;
               slot = slot_raw + HALF_S;
            end
         end else if (int'(slot_raw) < PHYS_APR_COUNT) begin
            src = SRC_APR;
         end
      end else if (aligned && win == WIN_NSAPR && REV_OK && HAS_GROUPS &&
                   !nonsecure && !virt && int'(slot_raw) < PHYS_APR_COUNT) begin
         src = SRC_NSAPR;
      end else if (offset == OFF_BPR) begin
         src = virt ? SRC_VBPR : SRC_BPR;
      end else if (offset == OFF_EOI) begin
         is_eoi = 1'b1;
      end
   end

endmodule

// File: rtl/cpuif_word_bank.sv
module cpuif_word_bank
#(
   parameter int NUM_CPUS = 4,
   parameter int WORDS    = 4,
   parameter int WIDTH    = 32,
   parameter int CPU_W    = 2,
   parameter int SLOT_W   = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CPU_W-1:0]  cpu,
   input  logic [SLOT_W-1:0] slot,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  rdata
);

   localparam int ENTRIES = NUM_CPUS * WORDS;

   logic [WIDTH-1:0] mem [ENTRIES];
   int               idx;
   logic             hit;

   always_comb begin
      idx = int'(cpu) * WORDS + int'(slot);
      hit = (int'(slot) < WORDS) && (idx < ENTRIES);
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)                      mem[e] <= RESET_VAL;
         else if (we && hit && idx == e)  mem[e] <= wdata;
      end
   end

   assign rdata = hit ? mem[idx] : '0;

endmodule

// File: rtl/cpuif_prio_regs.sv
module cpuif_prio_regs
   import cpuif_prio_pkg::*;
#(
   parameter int NUM_CPUS       = 4,
   parameter int PHYS_APR_COUNT = 4,
   parameter int VIRT_APR_COUNT = 1,
   parameter int PHYS_BPR_MIN   = 0,
   parameter int VIRT_BPR_MIN   = 2,
   parameter int ARCH_REV       = 2,
   parameter bit HAS_GROUPS     = 1'b1,
   localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  req_offset,
   input  logic               req_rd,
   input  logic               req_wr,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic               req_nonsecure,
   input  logic               req_virtual,
   input  logic [CPU_W-1:0]   req_cpu,
   output logic [DATA_W-1:0]  rd_data,
   output logic               eoi_valid,
   output logic [INTID_W-1:0] eoi_id,
   output logic [CPU_W-1:0]   eoi_cpu,
   output logic               eoi_virtual
);

   localparam logic [BPR_W-1:0] PMIN = BPR_W'(PHYS_BPR_MIN);
   localparam logic [BPR_W-1:0] VMIN = BPR_W'(VIRT_BPR_MIN);

   // elaboration-time parameter checks
   if (NUM_CPUS < 1) begin : g_bad_cpus
      $error("NUM_CPUS must be at least 1");
   end
   if (PHYS_APR_COUNT < 1 || PHYS_APR_COUNT > (1 << SLOT_W)) begin : g_bad_phys
      $error("PHYS_APR_COUNT must be 1..4");
   end
   if (VIRT_APR_COUNT < 1 || VIRT_APR_COUNT > PHYS_APR_COUNT) begin : g_bad_virt
      $error("VIRT_APR_COUNT must be 1..PHYS_APR_COUNT");
   end
   if (PHYS_BPR_MIN < 0 || PHYS_BPR_MIN > 7 || VIRT_BPR_MIN < 0 || VIRT_BPR_MIN > 7) begin : g_bad_bpr
      $error("binary-point floors must be 0..7");
   end

   src_e              dec_src;
   logic [SLOT_W-1:0] dec_slot;
   logic              dec_eoi;

   cpuif_decode #(
      .PHYS_APR_COUNT (PHYS_APR_COUNT),
      .VIRT_APR_COUNT (VIRT_APR_COUNT),
      .ARCH_REV       (ARCH_REV),
      .HAS_GROUPS     (HAS_GROUPS)
   ) u_decode (
      .offset    (req_offset),
      .nonsecure (req_nonsecure),
      .virt      (req_virtual),
      .src       (dec_src),
      .slot      (dec_slot),
      .is_eoi    (dec_eoi)
   );

   logic [DATA_W-1:0] apr_q, nsapr_q, hyp_q;
   logic [BPR_W-1:0]  bpr_q, vbpr_q;
   logic              bpr_we, vbpr_we;

   // priority banks only exist for the revision that defines them
   if (ARCH_REV == 2) begin : g_prio_banks
      logic apr_we, nsapr_we, hyp_we;
      assign apr_we   = req_wr && (dec_src == SRC_APR);
      assign nsapr_we = req_wr && (dec_src == SRC_NSAPR);
      assign hyp_we   = req_wr && (dec_src == SRC_HYP);

      cpuif_word_bank #(
         .NUM_CPUS (NUM_CPUS), .WORDS (PHYS_APR_COUNT), .WIDTH (DATA_W),
         .CPU_W (CPU_W), .SLOT_W (SLOT_W), .RESET_VAL ('0)
      ) u_apr (
         .clk (clk), .rst_n (rst_n), .we (apr_we), .cpu (req_cpu),
         .slot (dec_slot), .wdata (req_wdata), .rdata (apr_q)
      );

      if (HAS_GROUPS) begin : g_nsapr
         cpuif_word_bank #(
            .NUM_CPUS (NUM_CPUS), .WORDS (PHYS_APR_COUNT), .WIDTH (DATA_W),
            .CPU_W (CPU_W), .SLOT_W (SLOT_W), .RESET_VAL ('0)
         ) u_nsapr (
            .clk (clk), .rst_n (rst_n), .we (nsapr_we), .cpu (req_cpu),
            .slot (dec_slot), .wdata (req_wdata), .rdata (nsapr_q)
         );
      end else begin : g_no_nsapr
         assign nsapr_q = '0;
      end

      cpuif_word_bank #(
         .NUM_CPUS (NUM_CPUS), .WORDS (VIRT_APR_COUNT), .WIDTH (DATA_W),
         .CPU_W (CPU_W), .SLOT_W (SLOT_W), .RESET_VAL ('0)
      ) u_hyp (
         .clk (clk), .rst_n (rst_n), .we (hyp_we), .cpu (req_cpu),
         .slot (dec_slot), .wdata (req_wdata), .rdata (hyp_q)
      );
   end else begin : g_no_prio_banks
      assign apr_q   = '0;
      assign nsapr_q = '0;
      assign hyp_q   = '0;
   end

   assign bpr_we  = req_wr && (dec_src == SRC_BPR);
   assign vbpr_we = req_wr && (dec_src == SRC_VBPR);

   cpuif_word_bank #(
      .NUM_CPUS (NUM_CPUS), .WORDS (1), .WIDTH (BPR_W),
      .CPU_W (CPU_W), .SLOT_W (SLOT_W), .RESET_VAL (PMIN)
   ) u_bpr (
      .clk (clk), .rst_n (rst_n), .we (bpr_we), .cpu (req_cpu),
      .slot ('0), .wdata (bpr_clamp(req_wdata[BPR_W-1:0], PMIN)), .rdata (bpr_q)
   );

   cpuif_word_bank #(
      .NUM_CPUS (NUM_CPUS), .WORDS (1), .WIDTH (BPR_W),
      .CPU_W (CPU_W), .SLOT_W (SLOT_W), .RESET_VAL (VMIN)
   ) u_vbpr (
      .clk (clk), .rst_n (rst_n), .we (vbpr_we), .cpu (req_cpu),
      .slot ('0), .wdata (bpr_clamp(req_wdata[BPR_W-1:0], VMIN)), .rdata (vbpr_q)
   );

   logic [DATA_W-1:0] rd_next;

   always_comb begin
      unique case (dec_src)
         SRC_APR:   rd_next = apr_q;
         SRC_NSAPR: rd_next = nsapr_q;
         SRC_HYP:   rd_next = hyp_q;
         SRC_BPR:   rd_next = {{(DATA_W-BPR_W){1'b0}}, bpr_q};
         SRC_VBPR:  rd_next = {{(DATA_W-BPR_W){1'b0}}, vbpr_q};
         default:   rd_next = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data     <= '0;
         eoi_valid   <= 1'b0;
         eoi_id      <= '0;
         eoi_cpu     <= '0;
         eoi_virtual <= 1'b0;
      end else begin
         if (req_rd) rd_data <= rd_next;
         eoi_valid <= req_wr && dec_eoi;
         if (req_wr && dec_eoi) begin
            eoi_id      <= req_wdata[INTID_W-1:0];
            eoi_cpu     <= req_cpu;
            eoi_virtual <= req_virtual;
         end
      end
   end

endmodule

// File: rtl/cpuif_prio_regs_chk.sv
module cpuif_prio_regs_chk
   import cpuif_prio_pkg::*;
#(
   parameter int NUM_CPUS       = 4,
   parameter int VIRT_APR_COUNT = 1,
   parameter int VIRT_BPR_MIN   = 2,
   parameter int ARCH_REV       = 2,
   parameter int CPU_W          = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  req_offset,
   input logic               req_rd,
   input logic               req_wr,
   input logic [DATA_W-1:0]  req_wdata,
   input logic               req_nonsecure,
   input logic               req_virtual,
   input logic [CPU_W-1:0]   req_cpu,
   input logic [DATA_W-1:0]  rd_data,
   input logic               eoi_valid,
   input logic [INTID_W-1:0] eoi_id,
   input logic [CPU_W-1:0]   eoi_cpu,
   input logic               eoi_virtual
);

   logic in_apr_win, in_nsapr_win, eoi_req;
   assign in_apr_win   = (req_offset[ADDR_W-1:4] == WIN_APR);
   assign in_nsapr_win = (req_offset[ADDR_W-1:4] == WIN_NSAPR);
   assign eoi_req      = req_wr && (req_offset == OFF_EOI);

   a_r8_eoi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_req |=> eoi_valid && eoi_id == $past(req_wdata[INTID_W-1:0]) &&
                  eoi_cpu == $past(req_cpu) && eoi_virtual == $past(req_virtual));

   a_r8_eoi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !eoi_req |=> !eoi_valid);

   a_r5_nsapr_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      req_rd && in_nsapr_win && (req_nonsecure || req_virtual) |=> rd_data == '0);

   a_r4_virt_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
      req_rd && req_virtual && in_apr_win && int'(req_offset[3:2]) >= VIRT_APR_COUNT
      |=> rd_data == '0);

   a_r7_vbpr_floor: assert property (@(posedge clk) disable iff (!rst_n)
      req_rd && req_virtual && req_offset == OFF_BPR
      |=> rd_data[BPR_W-1:0] >= BPR_W'(VIRT_BPR_MIN) && rd_data[DATA_W-1:BPR_W] == '0);

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_rd |=> $stable(rd_data));

   a_r6_rev_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ARCH_REV != 2) && req_rd && (in_apr_win || in_nsapr_win) |=> rd_data == '0);

endmodule

bind cpuif_prio_regs cpuif_prio_regs_chk #(
   .NUM_CPUS       (NUM_CPUS),
   .VIRT_APR_COUNT (VIRT_APR_COUNT),
   .VIRT_BPR_MIN   (VIRT_BPR_MIN),
   .ARCH_REV       (ARCH_REV),
   .CPU_W          (CPU_W)
) u_chk (
   .clk (clk), .rst_n (rst_n), .req_offset (req_offset), .req_rd (req_rd),
   .req_wr (req_wr), .req_wdata (req_wdata), .req_nonsecure (req_nonsecure),
   .req_virtual (req_virtual), .req_cpu (req_cpu), .rd_data (rd_data),
   .eoi_valid (eoi_valid), .eoi_id (eoi_id), .eoi_cpu (eoi_cpu),
   .eoi_virtual (eoi_virtual)
);

// File: tb/cpuif_prio_regs_bench.sv
module cpuif_prio_regs_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] req_offset = '0;
   logic        req_rd = 1'b0, req_wr = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        req_nonsecure = 1'b0, req_virtual = 1'b0;
   logic [1:0]  req_cpu = '0;
   logic [31:0] rd_data, rd_data_r1;
   logic        eoi_valid, eoi_valid_r1;
   logic [9:0]  eoi_id, eoi_id_r1;
   logic [1:0]  eoi_cpu, eoi_cpu_r1;
   logic        eoi_virtual, eoi_virtual_r1;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   cpuif_prio_regs u_cpuif_prio_regs (
      .clk (clk), .rst_n (rst_n), .req_offset (req_offset), .req_rd (req_rd),
      .req_wr (req_wr), .req_wdata (req_wdata), .req_nonsecure (req_nonsecure),
      .req_virtual (req_virtual), .req_cpu (req_cpu), .rd_data (rd_data),
      .eoi_valid (eoi_valid), .eoi_id (eoi_id), .eoi_cpu (eoi_cpu),
      .eoi_virtual (eoi_virtual)
   );

   // second copy: revision 1, no interrupt groups
   cpuif_prio_regs #(.ARCH_REV (1), .HAS_GROUPS (1'b0)) u_rev1 (
      .clk (clk), .rst_n (rst_n), .req_offset (req_offset), .req_rd (req_rd),
      .req_wr (req_wr), .req_wdata (req_wdata), .req_nonsecure (req_nonsecure),
      .req_virtual (req_virtual), .req_cpu (req_cpu), .rd_data (rd_data_r1),
      .eoi_valid (eoi_valid_r1), .eoi_id (eoi_id_r1), .eoi_cpu (eoi_cpu_r1),
      .eoi_virtual (eoi_virtual_r1)
   );

   typedef struct packed {
      logic        is_rd;
      logic [11:0] off;
      logic [31:0] data;
      logic        ns;
      logic        vt;
      logic [1:0]  cpu;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 34;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 12'h0D8, 32'h0000_00A1, 1'b0, 1'b0, 2'd0, 32'h0,          8'd2},
      '{1'b1, 12'h0D8, 32'h0,         1'b0, 1'b0, 2'd0, 32'h0000_00A1,  8'd2},  // R2 secure word 2
      '{1'b1, 12'h0D8, 32'h0,         1'b0, 1'b0, 2'd1, 32'h0,          8'd2},  // R2 banked per cpu
      '{1'b1, 12'h0D0, 32'h0,         1'b1, 1'b0, 2'd0, 32'h0000_00A1,  8'd3},  // R3 ns idx0 -> word2
      '{1'b0, 12'h0D4, 32'h0000_00B2, 1'b1, 1'b0, 2'd0, 32'h0,          8'd3},
      '{1'b1, 12'h0DC, 32'h0,         1'b0, 1'b0, 2'd0, 32'h0000_00B2,  8'd3},  // R3 ns idx1 -> word3
      '{1'b0, 12'h0D8, 32'h0000_00FF, 1'b1, 1'b0, 2'd0, 32'h0,          8'd3},
      '{1'b1, 12'h0D8, 32'h0,         1'b1, 1'b0, 2'd0, 32'h0,          8'd3},  // R3 ns idx2 zero
      '{1'b1, 12'h0D0, 32'h0,         1'b0, 1'b0, 2'd0, 32'h0,          8'd3},  // R3 word0 untouched
      '{1'b0, 12'h0D0, 32'h0000_00C3, 1'b0, 1'b1, 2'd2, 32'h0,          8'd4},
      '{1'b1, 12'h0D0, 32'h0,         1'b0, 1'b1, 2'd2, 32'h0000_00C3,  8'd4},  // R4 hyp word
      '{1'b1, 12'h0D0, 32'h0,         1'b0, 1'b0, 2'd2, 32'h0,          8'd4},  // R4 physical untouched
      '{1'b1, 12'h0D0, 32'h0,         1'b0, 1'b1, 2'd1, 32'h0,          8'd4},  // R4 other host
      '{1'b0, 12'h0D4, 32'h0000_00DD, 1'b0, 1'b1, 2'd2, 32'h0,          8'd4},
      '{1'b1, 12'h0D4, 32'h0,         1'b0, 1'b1, 2'd2, 32'h0,          8'd4},  // R4 idx1 zero
      '{1'b1, 12'h0D0, 32'h0,         1'b0, 1'b1, 2'd2, 32'h0000_00C3,  8'd4},  // R4 no alias
      '{1'b0, 12'h0E4, 32'h0000_00E5, 1'b0, 1'b0, 2'd3, 32'h0,          8'd5},
      '{1'b1, 12'h0E4, 32'h0,         1'b0, 1'b0, 2'd3, 32'h0000_00E5,  8'd5},  // R5 secure
      '{1'b1, 12'h0E4, 32'h0,         1'b1, 1'b0, 2'd3, 32'h0,          8'd5},  // R5 ns zero
      '{1'b1, 12'h0E4, 32'h0,         1'b0, 1'b1, 2'd3, 32'h0,          8'd5},  // R5 virtual zero
      '{1'b0, 12'h0E4, 32'h0000_0011, 1'b1, 1'b0, 2'd3, 32'h0,          8'd5},
      '{1'b0, 12'h0E4, 32'h0000_0022, 1'b0, 1'b1, 2'd3, 32'h0,          8'd5},
      '{1'b1, 12'h0E4, 32'h0,         1'b0, 1'b0, 2'd3, 32'h0000_00E5,  8'd5},  // R5 writes dropped
      '{1'b0, 12'h008, 32'hFFFF_FFF5, 1'b0, 1'b0, 2'd1, 32'h0,          8'd7},
      '{1'b1, 12'h008, 32'h0,         1'b0, 1'b0, 2'd1, 32'h0000_0005,  8'd7},  // R7 low 3 bits
      '{1'b0, 12'h008, 32'h0000_0001, 1'b0, 1'b1, 2'd1, 32'h0,          8'd7},
      '{1'b1, 12'h008, 32'h0,         1'b0, 1'b1, 2'd1, 32'h0000_0002,  8'd7},  // R7 virtual floor
      '{1'b1, 12'h008, 32'h0,         1'b0, 1'b0, 2'd1, 32'h0000_0005,  8'd7},  // R7 separate regs
      '{1'b0, 12'h008, 32'h0000_0006, 1'b0, 1'b1, 2'd1, 32'h0,          8'd7},
      '{1'b1, 12'h008, 32'h0,         1'b0, 1'b1, 2'd1, 32'h0000_0006,  8'd7},  // R7 above floor
      '{1'b0, 12'h008, 32'h0000_0000, 1'b0, 1'b0, 2'd1, 32'h0,          8'd7},
      '{1'b1, 12'h008, 32'h0,         1'b0, 1'b0, 2'd1, 32'h0000_0000,  8'd7},  // R7 physical floor 0
      '{1'b1, 12'h100, 32'h0,         1'b0, 1'b0, 2'd0, 32'h0,          8'd9},  // R9 unmapped
      '{1'b1, 12'h0DA, 32'h0,         1'b0, 1'b0, 2'd0, 32'h0,          8'd9}   // R9 misaligned
   };

   task automatic check(input int req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // drive one cycle of strobes; outputs registered at the edge are
   // visible at the following falling edge, where this task returns
   task automatic access(input logic rd, input logic wr, input logic [11:0] off,
                         input logic [31:0] data, input logic ns, input logic vt,
                         input logic [1:0] cpu);
      req_rd = rd; req_wr = wr; req_offset = off; req_wdata = data;
      req_nonsecure = ns; req_virtual = vt; req_cpu = cpu;
      @(negedge clk);
      req_rd = 1'b0; req_wr = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(1, "rd_data after reset", rd_data, 32'h0);
      check(8, "eoi_valid after reset", {31'b0, eoi_valid}, 32'h0);
      access(1'b1, 1'b0, 12'h0D0, 32'h0, 1'b0, 1'b0, 2'd0);
      check(1, "apr reset", rd_data, 32'h0);
      access(1'b1, 1'b0, 12'h0E0, 32'h0, 1'b0, 1'b0, 2'd0);
      check(1, "nsapr reset", rd_data, 32'h0);
      access(1'b1, 1'b0, 12'h0D0, 32'h0, 1'b0, 1'b1, 2'd3);
      check(1, "hyp reset", rd_data, 32'h0);
      access(1'b1, 1'b0, 12'h008, 32'h0, 1'b0, 1'b0, 2'd2);
      check(1, "phys bpr reset", rd_data, 32'h0);
      access(1'b1, 1'b0, 12'h008, 32'h0, 1'b0, 1'b1, 2'd2);
      check(1, "virt bpr reset", rd_data, 32'h2);

      // vector table
      for (int i = 0; i < NV; i++) begin
         access(VECS[i].is_rd, !VECS[i].is_rd, VECS[i].off, VECS[i].data,
                VECS[i].ns, VECS[i].vt, VECS[i].cpu);
         if (VECS[i].is_rd)
            check(int'(VECS[i].req), $sformatf("vector %0d", i), rd_data, VECS[i].exp);
      end

      // R8 end-of-interrupt notification
      access(1'b0, 1'b1, 12'h010, 32'hFFFF_F3A5, 1'b1, 1'b1, 2'd2);
      check(8, "eoi_valid pulse", {31'b0, eoi_valid}, 32'h1);
      check(8, "eoi_id", {22'b0, eoi_id}, 32'h3A5);
      check(8, "eoi_cpu", {30'b0, eoi_cpu}, 32'h2);
      check(8, "eoi_virtual", {31'b0, eoi_virtual}, 32'h1);
      check(9, "rd_data held across write", rd_data, 32'h0);
      @(negedge clk);
      check(8, "eoi_valid single cycle", {31'b0, eoi_valid}, 32'h0);

      // R10 read and write of the same word together
      access(1'b1, 1'b1, 12'h0DC, 32'h0000_0077, 1'b0, 1'b0, 2'd0);
      check(10, "same-cycle read returns old", rd_data, 32'h0000_00B2);
      access(1'b1, 1'b0, 12'h0DC, 32'h0, 1'b0, 1'b0, 2'd0);
      check(10, "same-cycle write landed", rd_data, 32'h0000_0077);

      // R9 hold without read strobe
      access(1'b0, 1'b1, 12'h0D0, 32'h0000_0055, 1'b0, 1'b0, 2'd0);
      check(9, "rd_data held", rd_data, 32'h0000_0077);

      // R6 revision 1 / no groups copy
      access(1'b1, 1'b0, 12'h0D0, 32'h0, 1'b0, 1'b0, 2'd0);
      check(2, "main word0 written", rd_data, 32'h0000_0055);
      check(6, "rev1 apr zero", rd_data_r1, 32'h0);
      access(1'b0, 1'b1, 12'h0E0, 32'h0000_0066, 1'b0, 1'b0, 2'd0);
      access(1'b1, 1'b0, 12'h0E0, 32'h0, 1'b0, 1'b0, 2'd0);
      check(5, "main nsapr written", rd_data, 32'h0000_0066);
      check(6, "rev1 nsapr zero", rd_data_r1, 32'h0);
      access(1'b0, 1'b1, 12'h008, 32'h0000_0003, 1'b0, 1'b0, 2'd2);
      access(1'b1, 1'b0, 12'h008, 32'h0, 1'b0, 1'b0, 2'd2);
      check(7, "rev1 bpr still works", rd_data_r1, 32'h3);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule